// File: doc/BRIEF.md
# I2C Stuck-Data Bus Recovery Engine

This engine sits beside the byte engine of an I2C master and watches the two bus lines while the master has nothing in progress. If a slave was cut off part-way through a read, it can keep SDA low indefinitely. The engine catches this case when SDA stays low with SCL high for a programmed number of clock cycles. It then clocks SCL itself so that the slave can shift out the rest of its byte and its acknowledge slot.

Each SCL pulse consists of a driven-low phase and a released phase, each a programmed number of cycles long. SDA is sampled on the last cycle of every released phase. Once SDA reads high, the engine stops clocking, generates a STOP and reports success. If SDA is still low after the last allowed pulse, it lets go of both lines and reports failure. The pulse limit is 9 by default and 18 in long mode; long mode covers a second master whose general-call transfer holds SDA low for a further byte. A separate watcher reports SCL held low by something outside the engine. Both lines are open-drain: the engine only ever asserts a pull-low enable.

The engine has no data stream, so all of its pins are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, and whenever `busy` is 0, `scl_drive_low` and `sda_drive_low` are 0 and no status pulse is active.
- R2: Recovery starts (`busy` rises) when, while idle, SDA has been read low with SCL high, `enable`=1 and `bus_idle`=1 for `stuck_limit` consecutive cycles. A shorter low stretch starts nothing.
- R3: While `bus_idle`=0 or `enable`=0, a low SDA never starts a recovery.
- R4: Every SCL driven-low phase lasts exactly `half_period` cycles, and so does every released phase. SDA is sampled on the last cycle of each released phase.
- R5: The engine stops pulsing after the first pulse whose sample reads SDA high. The number of pulses issued equals the number of pulses the slave needed.
- R6: With `long_mode`=0 at most 9 pulses are issued. If SDA is still low at the 9th sample, `failed` pulses for one cycle and both lines are released.
- R7: With `long_mode`=1 the limit is 18 pulses, with the same failure behaviour.
- R8: After a successful sample the engine drives SCL and SDA low for `half_period` cycles, then releases SCL with SDA still low for `half_period` cycles, then releases SDA (a STOP). `recovered` pulses in the cycle SDA is released. SDA is never released while SCL is driven low.
- R9: When SCL reads low for `stuck_limit` consecutive cycles while the engine is idle and `enable`=1, `scl_fault` pulses once for that episode.
- R10: Lines are open-drain. Each output is a pull-low enable, and a released line is high unless another device pulls it low.
- R11: `recovered` and `failed` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows fault watching and recovery |
| long_mode | input | 1 | 1: limit 18 pulses, 0: limit 9 |
| bus_idle | input | 1 | The master's byte engine is idle |
| stuck_limit | input | TO_W | Consecutive low cycles before a fault is declared (at least 1) |
| half_period | input | HP_W | Cycles per SCL phase (at least 1) |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_drive_low | output | 1 | Pull SCL low |
| sda_drive_low | output | 1 | Pull SDA low |
| busy | output | 1 | A recovery is in progress |
| recovered | output | 1 | One-cycle pulse: bus freed and STOP sent |
| failed | output | 1 | One-cycle pulse: pulse limit reached with SDA low |
| scl_fault | output | 1 | One-cycle pulse: SCL held low externally |

## Verification
The bench builds the engine with the default widths, a `stuck_limit` of 20 and a `half_period` of 3. With these values a full 18-pulse recovery takes about a hundred cycles, so both pulse limits and the cases just beyond them (9 and 10 pulses in short mode, 18 and 19 in long mode) all fit in a short run. The 3-cycle phase is long enough that a wrong phase length shows up as a wrong measured low time. The 20-cycle limit leaves room for a 10-cycle SDA glitch that must be ignored.

// File: rtl/i2c_bus_clear_pkg.sv
package i2c_bus_clear_pkg;
  typedef enum logic [2:0] {
    BC_IDLE,
    BC_LOW,
    BC_HIGH,
    BC_STOP_LOW,
    BC_STOP_SETUP
  } bc_state_e;

  localparam int unsigned WATCH_SDA = 0;
  localparam int unsigned WATCH_SCL = 1;
  localparam int unsigned WATCH_N   = 2;
endpackage

// File: rtl/bc_stuck_watch.sv
module bc_stuck_watch #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cond,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt;

  // Saturates at the limit so that one episode fires once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!cond)       cnt <= '0;
    else if (cnt < limit) cnt <= cnt + 1'b1;
  end

  assign fire = cond && (cnt == limit - 1'b1);
endmodule

// File: rtl/bc_phase_timer.sv
module bc_phase_timer #(
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bus_clear_pkg::*;
#(
  parameter int unsigned TO_W         = 16,
  parameter int unsigned HP_W         = 8,
  parameter int unsigned SHORT_PULSES = 9,
  parameter int unsigned LONG_PULSES  = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            long_mode,
  input  logic            bus_idle,
  input  logic [TO_W-1:0] stuck_limit,
  input  logic [HP_W-1:0] half_period,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            scl_drive_low,
  output logic            sda_drive_low,
  output logic            busy,
  output logic            recovered,
  output logic            failed,
  output logic            scl_fault
);
  localparam int unsigned PC_W = $clog2(LONG_PULSES + 1);

  bc_state_e       state;
  logic [PC_W-1:0] pulses;
  logic [PC_W-1:0] pulses_nxt;
  logic [PC_W-1:0] pulse_max;
  logic            tick;
  logic            idle_q;
  logic [WATCH_N-1:0] watch_cond;
  logic [WATCH_N-1:0] watch_fire;

  assign idle_q = (state == BC_IDLE);
  assign watch_cond[WATCH_SDA] = idle_q && enable && bus_idle && scl_in && !sda_in;
  assign watch_cond[WATCH_SCL] = idle_q && enable && !scl_in;

  for (genvar g = 0; g < WATCH_N; g++) begin : g_watch
    bc_stuck_watch #(.CW(TO_W)) u_watch (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (watch_cond[g]),
      .limit (stuck_limit),
      .fire  (watch_fire[g])
    );
  end

  bc_phase_timer #(.HW(HP_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!idle_q),
    .half  (half_period),
    .tick  (tick)
  );

  assign pulse_max  = long_mode ? PC_W'(LONG_PULSES) : PC_W'(SHORT_PULSES);
  assign pulses_nxt = pulses + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= BC_IDLE;
      pulses    <= '0;
      recovered <= 1'b0;
      failed    <= 1'b0;
      scl_fault <= 1'b0;
    end else begin
      recovered <= 1'b0;
      failed    <= 1'b0;
      scl_fault <= watch_fire[WATCH_SCL];
      unique case (state)
        BC_IDLE: if (watch_fire[WATCH_SDA]) begin
          state  <= BC_LOW;
          pulses <= '0;
        end
        BC_LOW: if (tick) state <= BC_HIGH;
        BC_HIGH: if (tick) begin
          pulses <= pulses_nxt;
          if (sda_in)                       state <= BC_STOP_LOW;
          else if (pulses_nxt >= pulse_max) begin
            state  <= BC_IDLE;
            failed <= 1'b1;
          end else                          state <= BC_LOW;
        end
        BC_STOP_LOW: if (tick) state <= BC_STOP_SETUP;
        BC_STOP_SETUP: if (tick) begin
          state     <= BC_IDLE;
          recovered <= 1'b1;
        end
        default: state <= BC_IDLE;
      endcase
    end
  end

  assign busy          = !idle_q;
  assign scl_drive_low = (state == BC_LOW) || (state == BC_STOP_LOW);
  assign sda_drive_low = (state == BC_STOP_LOW) || (state == BC_STOP_SETUP);
endmodule

// File: rtl/i2c_bus_clear_checker.sv
module i2c_bus_clear_checker #(
  parameter int unsigned SHORT_PULSES = 9,
  parameter int unsigned LONG_PULSES  = 18
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic bus_idle,
  input logic long_mode,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic busy,
  input logic recovered,
  input logic failed
);
  logic [7:0] low_rises;
  logic       scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_rises <= '0;
      scl_q     <= 1'b0;
    end else begin
      scl_q <= scl_drive_low;
      if (!busy)                        low_rises <= '0;
      else if (scl_drive_low && !scl_q) low_rises <= low_rises + 1'b1;
    end
  end

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_drive_low && !sda_drive_low));
  p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable && bus_idle));
  p_done_from_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (recovered || failed) |-> $past(busy));
  // R6 / R7: pulse limit plus the single STOP low phase
  p_pulse_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (low_rises <= (long_mode ? LONG_PULSES + 1 : SHORT_PULSES + 1)));
  p_stop_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> !scl_drive_low);
  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(recovered && failed));
  p_status_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (recovered || failed) |=> !(recovered || failed));
endmodule

bind i2c_bus_clear i2c_bus_clear_checker #(
  .SHORT_PULSES (SHORT_PULSES),
  .LONG_PULSES  (LONG_PULSES)
) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .bus_idle      (bus_idle),
  .long_mode     (long_mode),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .busy          (busy),
  .recovered     (recovered),
  .failed        (failed)
);

// File: tb/tb_i2c_bus_clear.sv
module tb_i2c_bus_clear;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20;
  localparam int HALF       = 3;
  localparam int K_REC      = 0;
  localparam int K_FAIL     = 1;
  localparam int K_SCL      = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, long_mode = 1'b0, bus_idle = 1'b1;
  logic sda_force = 1'b0, scl_force = 1'b0;
  logic scl_drive_low, sda_drive_low, busy, recovered, failed, scl_fault;
  logic scl_line, sda_line;
  int   slave_k = 0;
  int   req_val = 0;
  logic req_load = 1'b0;
  int   checks = 0, errors = 0, cycles = 0;
  int   exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !scl_drive_low && !scl_force;
  assign sda_line = !sda_drive_low && !sda_force && (slave_k == 0);

  i2c_bus_clear dut (
    .clk (clk), .rst_n (rst_n), .enable (enable), .long_mode (long_mode),
    .bus_idle (bus_idle), .stuck_limit (16'(LIMIT)), .half_period (8'(HALF)),
    .scl_in (scl_line), .sda_in (sda_line), .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low), .busy (busy), .recovered (recovered),
    .failed (failed), .scl_fault (scl_fault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Slave model: holds SDA low until it has seen slave_k SCL rising edges.
  logic scl_prev = 1'b1;
  always @(negedge clk) begin
    if (req_load) slave_k <= req_val;
    else if (scl_line && !scl_prev && slave_k > 0) slave_k <= slave_k - 1;
    scl_prev <= scl_line;
  end

  task automatic load_slave(input int k);
    @(posedge clk); req_val = k; req_load = 1'b1;
    @(posedge clk); req_load = 1'b0;
  endtask

  // Monitor: measures pulses and phases, pops the scoreboard on each status pulse.
  int   rel_cnt = 0, low_len = 0;
  bit   phase_bad = 0, stop_bad = 0;
  logic scl_oe_q = 1'b0, sda_oe_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_drive_low) low_len++;
      else if (scl_oe_q) begin
        if (low_len != HALF) phase_bad = 1;
        low_len = 0;
        if (!sda_drive_low) rel_cnt++;
      end
      if (sda_oe_q && !sda_drive_low && scl_drive_low) stop_bad = 1;
      if (recovered || failed || scl_fault) begin
        int kind, exp;
        check(!(recovered && failed), "R11", int'(recovered && failed), 0);
        kind = recovered ? K_REC : (failed ? K_FAIL : K_SCL);
        if (exp_q.size() == 0) begin
          check(0, "R11 unexpected status", kind, -1);
        end else begin
          exp = exp_q.pop_front();
          check(kind * 100 + rel_cnt == exp, "R5 R6 R7 R9 event/pulses", kind * 100 + rel_cnt, exp);
          if (recovered) begin
            check(!stop_bad, "R8 STOP ordering", int'(stop_bad), 0);
            check(!phase_bad, "R4 phase length", int'(phase_bad), 0);
            check(!scl_drive_low && !sda_drive_low && sda_line, "R10 lines released",
                  int'(sda_line), 1);
          end
        end
        rel_cnt = 0; phase_bad = 0; stop_bad = 0;
      end
      scl_oe_q = scl_drive_low;
      sda_oe_q = sda_drive_low;
    end
  end

  task automatic run_case(input int k, input logic lm, input int kind, input int n);
    long_mode = lm;
    exp_q.push_back(kind * 100 + n);
    load_slave(k);
    wait (exp_q.size() == 0);
    if (kind == K_FAIL) load_slave(0);
    repeat (10) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!scl_drive_low && !sda_drive_low && !busy && !recovered && !failed && !scl_fault,
          "R1 reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    repeat (2) @(posedge clk);

    // R2: a glitch shorter than the limit is ignored
    @(posedge clk); sda_force = 1'b1;
    repeat (LIMIT/2) @(posedge clk);
    sda_force = 1'b0;
    repeat (2*LIMIT) @(posedge clk);
    @(negedge clk);
    check(!busy && !scl_drive_low, "R2 short glitch ignored", int'(busy), 0);

    // R3: byte engine busy blocks detection, then R2 starts it once idle
    bus_idle = 1'b0;
    load_slave(5);
    repeat (3*LIMIT) @(posedge clk);
    @(negedge clk);
    check(!busy && !scl_drive_low, "R3 blocked by bus_idle", int'(busy), 0);
    exp_q.push_back(K_REC * 100 + 5);
    bus_idle = 1'b1;
    wait (exp_q.size() == 0);
    repeat (10) @(posedge clk);

    // R3: disabled engine ignores stuck SDA
    enable = 1'b0;
    load_slave(4);
    repeat (3*LIMIT) @(posedge clk);
    @(negedge clk);
    check(!busy && !scl_drive_low, "R3 blocked by enable", int'(busy), 0);
    load_slave(0);
    enable = 1'b1;
    repeat (5) @(posedge clk);

    run_case(1,  1'b0, K_REC,  1);   // R5 single pulse
    run_case(9,  1'b0, K_REC,  9);   // R6 boundary
    run_case(10, 1'b0, K_FAIL, 9);   // R6 limit exceeded
    run_case(10, 1'b1, K_REC,  10);  // R7 long mode
    run_case(18, 1'b1, K_REC,  18);  // R7 boundary
    run_case(19, 1'b1, K_FAIL, 18);  // R7 limit exceeded

    // R9: SCL held low externally, reported once
    exp_q.push_back(K_SCL * 100);
    @(posedge clk); scl_force = 1'b1;
    repeat (3*LIMIT) @(posedge clk);
    scl_force = 1'b0;
    repeat (5) @(posedge clk);
    check(exp_q.size() == 0, "R9 scl fault reported", exp_q.size(), 0);
    check(!busy, "R9 no recovery from SCL fault", int'(busy), 0);

    repeat (20) @(posedge clk);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule